// File: doc/BRIEF.md
# Software Write-Protection Command Decoder

This block sits between the host bus of a byte-wide nonvolatile memory and its page-load logic. It examines every byte-load cycle, given as an address and data pair on a one-cycle write strobe, and classifies it. A cycle can be one step of a multi-cycle command, a data byte to pass on to the page buffer, a stray write that must be refused, or nothing at all. The block holds the global protection flag, the identification-mode flag, a refusal lockout and the page-load window. It also answers identification reads. Array storage and program/erase timing live elsewhere; this block only issues a load pulse per accepted byte and an erase pulse per accepted chip-erase command.

Commands use two key cycles: data AAh at address 5555h, then data 55h at address 2AAAh. Only the low 15 address bits are compared. A third cycle at 5555h then picks the action:
- A0h unlocks a protected page load. The first time it is used, it also turns protection on for the whole array.
- 90h enters identification mode.
- F0h leaves identification mode.
- 80h opens an extended command. The extended command repeats the two key cycles, then ends at 5555h with 20h to remove protection or 10h to erase the chip.

Protection comes up cleared after reset. Window and lockout lengths are given in clock cycles.

Top module: `sdp_cmd_decoder`

## Requirements
- R1: After reset, prot_on, id_mode, lock_busy, win_open, load_fire, erase_go and rd_valid are all 0.
- R2: With protection off, outside identification mode and lockout, a write that is not consumed as a command step gives load_fire=1 in the next cycle, with load_addr and load_data equal to the written pair.
- R3: The cycles (5555h,AAh), (2AAAh,55h), (5555h,A0h) set prot_on=1 and win_open=1 in the cycle after the third one. Only address bits [14:0] are compared. None of the three cycles is loaded.
- R4: While win_open=1, every write is loaded and the window restarts at WIN_CYC cycles. After WIN_CYC consecutive cycles with no write, win_open falls to 0.
- R5: With protection on, the window closed, and not in identification mode, a write that is not a command step is not loaded. It sets lock_busy for LOCK_CYC cycles. Further stray writes during the lockout have no effect and do not extend it.
- R6: The six cycles AAh, 55h, 80h, AAh, 55h, 20h, at addresses 5555h, 2AAAh, 5555h, 5555h, 2AAAh, 5555h, clear prot_on. Nothing other than this command and reset clears it.
- R7: The same six-cycle form ending in 10h gives a one-cycle erase_go pulse and leaves prot_on unchanged.
- R8: Key cycles followed by (5555h,90h) set id_mode. A read with rd_en in identification mode gives rd_valid=1 in the next cycle. rd_data is BFh for address 0, DEV_CODE (default 07h) for address 1, and 00h for any other address. Outside identification mode rd_valid stays 0.
- R9: Key cycles followed by (5555h,F0h) clear id_mode and end any lockout at once.
- R10: A write that does not match the next expected step aborts a partial command without changing any state. If that write is itself (5555h,AAh), it starts a new command. Otherwise it is handled as a stray write under R2, R5 or R11.
- R11: In identification mode, stray writes are neither loaded nor cause a lockout.
- R12: During a lockout, completed commands other than the identification exit have no effect: no erase pulse, no window, no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte-load cycle strobe |
| wr_addr | input | AW | Byte-load address |
| wr_data | input | 8 | Byte-load data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| load_fire | output | 1 | Accepted byte for the page buffer |
| load_addr | output | AW | Address of the accepted byte |
| load_data | output | 8 | Data of the accepted byte |
| erase_go | output | 1 | Chip-erase request pulse |
| prot_on | output | 1 | Global protection flag |
| id_mode | output | 1 | Identification mode flag |
| lock_busy | output | 1 | Refusal lockout active |
| win_open | output | 1 | Protected page-load window open |
| rd_valid | output | 1 | Identification read data valid |
| rd_data | output | 8 | Identification read data |

## Verification
The bench targets several corner cases:
- The first unlock on an unprotected part. A design that treated it as a plain load would leave protection off.
- A sequence broken by a second AAh. A design that dropped that cycle would miss the restarted command.
- A broken extended command under protection. It must lock out without touching the flag; a design that used partial sequences would clear protection.
- Commands issued inside a lockout, where only the exit may act. A design without the mask would erase or open a window.
- Stray writes in lockout and identification mode, which must neither load nor extend or start a lockout.

Randomized command scripts with corrupted bytes are compared cycle by cycle against a bench model built from the requirements.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    localparam int CMD_AW = 15;

    localparam logic [CMD_AW-1:0] ADDR_ODD  = 15'h5555;
    localparam logic [CMD_AW-1:0] ADDR_EVEN = 15'h2AAA;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] OP_UNLOCK   = 8'hA0;
    localparam logic [7:0] OP_EXTEND   = 8'h80;
    localparam logic [7:0] OP_ID_ENTER = 8'h90;
    localparam logic [7:0] OP_ID_LEAVE = 8'hF0;
    localparam logic [7:0] OP_UNPROT   = 8'h20;
    localparam logic [7:0] OP_ERASE    = 8'h10;
    localparam logic [7:0] MFR_CODE    = 8'hBF;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_EXT, SQ_EKEY1, SQ_EKEY2
    } seq_state_e;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_UNLOCK, CMD_ID_ENTER, CMD_ID_LEAVE, CMD_UNPROTECT, CMD_ERASE
    } cmd_e;

    typedef struct packed {
        logic hit;
        cmd_e cmd;
    } seq_res_t;

    function automatic logic is_key1(input logic [CMD_AW-1:0] a, input logic [7:0] d);
        return (a == ADDR_ODD) && (d == KEY_FIRST);
    endfunction

    function automatic logic is_key2(input logic [CMD_AW-1:0] a, input logic [7:0] d);
        return (a == ADDR_EVEN) && (d == KEY_SECOND);
    endfunction

    function automatic cmd_e short_op(input logic [7:0] d);
        case (d)
            OP_UNLOCK:   return CMD_UNLOCK;
            OP_ID_ENTER: return CMD_ID_ENTER;
            OP_ID_LEAVE: return CMD_ID_LEAVE;
            default:     return CMD_NONE;
        endcase
    endfunction

    function automatic cmd_e long_op(input logic [7:0] d);
        case (d)
            OP_UNPROT: return CMD_UNPROTECT;
            OP_ERASE:  return CMD_ERASE;
            default:   return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sdp_seq.sv
module sdp_seq
    import sdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CMD_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output seq_res_t          res
);

    seq_state_e st, st_n;
    logic k1, k2, on_odd, brk;
    cmd_e sop, lop;

    assign k1     = is_key1(wr_addr, wr_data);
    assign k2     = is_key2(wr_addr, wr_data);
    assign on_odd = (wr_addr == ADDR_ODD);
    assign sop    = short_op(wr_data);
    assign lop    = long_op(wr_data);

    always_comb begin
        st_n    = st;
        res.hit = 1'b0;
        res.cmd = CMD_NONE;
        brk     = 1'b0;
        if (wr_en) begin
            case (st)
                SQ_IDLE: begin
                    if (k1) begin
                        st_n    = SQ_KEY1;
                        res.hit = 1'b1;
                    end
                end
                SQ_KEY1: begin
                    if (k2) begin
                        st_n    = SQ_KEY2;
                        res.hit = 1'b1;
                    end else brk = 1'b1;
                end
                SQ_KEY2: begin
                    if (on_odd && wr_data == OP_EXTEND) begin
                        st_n    = SQ_EXT;
                        res.hit = 1'b1;
                    end else if (on_odd && sop != CMD_NONE) begin
                        st_n    = SQ_IDLE;
                        res.hit = 1'b1;
                        res.cmd = sop;
                    end else brk = 1'b1;
                end
                SQ_EXT: begin
                    if (k1) begin
                        st_n    = SQ_EKEY1;
                        res.hit = 1'b1;
                    end else brk = 1'b1;
                end
                SQ_EKEY1: begin
                    if (k2) begin
                        st_n    = SQ_EKEY2;
                        res.hit = 1'b1;
                    end else brk = 1'b1;
                end
                SQ_EKEY2: begin
                    if (on_odd && lop != CMD_NONE) begin
                        st_n    = SQ_IDLE;
                        res.hit = 1'b1;
                        res.cmd = lop;
                    end else brk = 1'b1;
                end
                default: st_n = SQ_IDLE;
            endcase
            if (brk) begin
                if (k1) begin
                    st_n    = SQ_KEY1;
                    res.hit = 1'b1;
                end else begin
                    st_n = SQ_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= SQ_IDLE;
        else     st <= st_n;
    end

    // R10: a completed command only ever comes from a consumed write
    assert_cmd_on_write_R10: assert property (@(posedge clk) disable iff (rst)
        (res.cmd != CMD_NONE) |-> (wr_en && res.hit));

    // R10: an unconsumed write leaves the sequencer idle
    assert_break_to_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !res.hit) |=> (st == SQ_IDLE));

endmodule

// File: rtl/sdp_ctrl.sv
module sdp_ctrl
    import sdp_pkg::*;
#(
    parameter int WIN_CYC  = 16,
    parameter int LOCK_CYC = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  seq_res_t res,
    output logic     prot_on,
    output logic     id_mode,
    output logic     lock_busy,
    output logic     win_open,
    output logic     load_req,
    output logic     erase_req
);

    localparam int WW = $clog2(WIN_CYC + 1);
    localparam int LW = $clog2(LOCK_CYC + 1);

    logic [WW-1:0] win_cnt;
    logic [LW-1:0] lock_cnt;
    logic          stray, lock_start;
    cmd_e          eff;

    assign win_open  = (win_cnt != '0);
    assign lock_busy = (lock_cnt != '0);

    assign stray      = wr_en && !win_open && !res.hit;
    assign lock_start = stray && prot_on && !id_mode && !lock_busy;
    assign load_req   = wr_en && (win_open || (stray && !prot_on && !id_mode && !lock_busy));

    always_comb begin
        eff = res.cmd;
        if (lock_busy && res.cmd != CMD_ID_LEAVE) eff = CMD_NONE;
    end

    assign erase_req = (eff == CMD_ERASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_on  <= 1'b0;
            id_mode  <= 1'b0;
            win_cnt  <= '0;
            lock_cnt <= '0;
        end else begin
            case (eff)
                CMD_UNLOCK:    prot_on <= 1'b1;
                CMD_UNPROTECT: prot_on <= 1'b0;
                CMD_ID_ENTER:  id_mode <= 1'b1;
                CMD_ID_LEAVE:  id_mode <= 1'b0;
                default: ;
            endcase

            if (lock_start)                lock_cnt <= LW'(LOCK_CYC);
            else if (eff == CMD_ID_LEAVE)  lock_cnt <= '0;
            else if (lock_busy)            lock_cnt <= lock_cnt - LW'(1);

            if (eff == CMD_UNLOCK || (wr_en && win_open)) win_cnt <= WW'(WIN_CYC);
            else if (win_open)                            win_cnt <= win_cnt - WW'(1);
        end
    end

    // R3: protection is only raised by a completed unlock
    assert_prot_set_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_on) |-> $past(eff == CMD_UNLOCK));

    // R6: protection is only dropped by the unprotect command
    assert_prot_clear_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(prot_on) |-> $past(eff == CMD_UNPROTECT));

    // R5: a lockout starts only from a protected, closed-window write
    assert_lock_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_busy) |-> ($past(prot_on) && !$past(win_open) && $past(wr_en)));

    // R12: commands other than the exit are masked while locked
    assert_lock_mask_R12: assert property (@(posedge clk) disable iff (rst)
        (lock_busy && res.cmd != CMD_ID_LEAVE) |=> ($stable(prot_on) && $stable(id_mode) && !win_open));

endmodule

// File: rtl/sdp_idrd.sv
module sdp_idrd
    import sdp_pkg::*;
#(
    parameter int         AW       = 17,
    parameter logic [7:0] DEV_CODE = 8'h07
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          id_mode,
    output logic          rd_valid,
    output logic [7:0]    rd_data
);

    logic [7:0] sel;

    always_comb begin
        if (rd_addr == AW'(0))      sel = MFR_CODE;
        else if (rd_addr == AW'(1)) sel = DEV_CODE;
        else                        sel = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            rd_valid <= rd_en && id_mode;
            rd_data  <= (rd_en && id_mode) ? sel : 8'h00;
        end
    end

    // R8: read data is only returned while identification mode was active
    assert_rd_in_id_R8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(id_mode) && $past(rd_en)));

    // R8: address 0 always returns the manufacturer byte
    assert_rd_mfr_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && id_mode && rd_addr == AW'(0)) |=> (rd_valid && rd_data == MFR_CODE));

endmodule

// File: rtl/sdp_cmd_decoder.sv
module sdp_cmd_decoder
    import sdp_pkg::*;
#(
    parameter int         AW       = 17,
    parameter logic [7:0] DEV_CODE = 8'h07,
    parameter int         WIN_CYC  = 16,
    parameter int         LOCK_CYC = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          load_fire,
    output logic [AW-1:0] load_addr,
    output logic [7:0]    load_data,
    output logic          erase_go,
    output logic          prot_on,
    output logic          id_mode,
    output logic          lock_busy,
    output logic          win_open,
    output logic          rd_valid,
    output logic [7:0]    rd_data
);

    seq_res_t res;
    logic     load_req, erase_req, seq_wr;

    assign seq_wr = wr_en && !win_open;

    sdp_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (seq_wr),
        .wr_addr (wr_addr[CMD_AW-1:0]),
        .wr_data (wr_data),
        .res     (res)
    );

    sdp_ctrl #(.WIN_CYC(WIN_CYC), .LOCK_CYC(LOCK_CYC)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .res       (res),
        .prot_on   (prot_on),
        .id_mode   (id_mode),
        .lock_busy (lock_busy),
        .win_open  (win_open),
        .load_req  (load_req),
        .erase_req (erase_req)
    );

    sdp_idrd #(.AW(AW), .DEV_CODE(DEV_CODE)) u_idrd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .id_mode  (id_mode),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            load_fire <= 1'b0;
            erase_go  <= 1'b0;
            load_addr <= '0;
            load_data <= 8'h00;
        end else begin
            load_fire <= load_req;
            erase_go  <= erase_req;
            if (load_req) begin
                load_addr <= wr_addr;
                load_data <= wr_data;
            end
        end
    end

    // R11: no byte is loaded out of identification mode's stray writes
    assert_no_id_load_R11: assert property (@(posedge clk) disable iff (rst)
        load_fire |-> ($past(win_open) || !$past(id_mode)));

    // R7: the erase request is a single-cycle pulse
    assert_erase_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        erase_go |=> !erase_go);

    // R2: a load always echoes a write of the previous cycle
    assert_load_from_write_R2: assert property (@(posedge clk) disable iff (rst)
        load_fire |-> $past(wr_en));

endmodule

// File: tb/tb_sdp_cmd_decoder.sv
module tb_sdp_cmd_decoder;

    localparam int         AW   = 17;
    localparam int         WIN  = 16;
    localparam int         LOCK = 32;
    localparam logic [7:0] DEV  = 8'h07;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]    wr_data = 8'h00;
    logic          load_fire, erase_go, prot_on, id_mode, lock_busy, win_open, rd_valid;
    logic [AW-1:0] load_addr;
    logic [7:0]    load_data, rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdp_cmd_decoder #(.AW(AW), .DEV_CODE(DEV), .WIN_CYC(WIN), .LOCK_CYC(LOCK)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .load_fire(load_fire), .load_addr(load_addr),
        .load_data(load_data), .erase_go(erase_go), .prot_on(prot_on), .id_mode(id_mode),
        .lock_busy(lock_busy), .win_open(win_open), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // reference model state
    int         m_seq, m_lock, m_win;
    bit         m_prot, m_id;
    bit         e_load, e_er, e_rdv;
    logic [16:0] e_la;
    logic [7:0] e_ld, e_rdd;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_seq = 0; m_lock = 0; m_win = 0; m_prot = 0; m_id = 0;
        e_load = 0; e_er = 0; e_rdv = 0; e_la = '0; e_ld = '0; e_rdd = '0;
    endfunction

    function automatic void model_step(input bit w, input logic [16:0] a, input logic [7:0] d,
                                       input bit r, input logic [16:0] ra);
        bit hit = 0, brk = 0, wopen, locked, stray, k1, k2, on_a;
        int cmd = 0, eff, nseq;
        nseq   = m_seq;
        wopen  = (m_win != 0);
        locked = (m_lock != 0);
        k1   = (a[14:0] == 15'h5555) && (d == 8'hAA);
        k2   = (a[14:0] == 15'h2AAA) && (d == 8'h55);
        on_a = (a[14:0] == 15'h5555);
        if (w && !wopen) begin
            case (m_seq)
                0: if (k1) begin nseq = 1; hit = 1; end
                1: if (k2) begin nseq = 2; hit = 1; end else brk = 1;
                2: begin
                    if (on_a && d == 8'h80) begin nseq = 3; hit = 1; end
                    else if (on_a && d == 8'hA0) begin nseq = 0; hit = 1; cmd = 1; end
                    else if (on_a && d == 8'h90) begin nseq = 0; hit = 1; cmd = 2; end
                    else if (on_a && d == 8'hF0) begin nseq = 0; hit = 1; cmd = 3; end
                    else brk = 1;
                end
                3: if (k1) begin nseq = 4; hit = 1; end else brk = 1;
                4: if (k2) begin nseq = 5; hit = 1; end else brk = 1;
                default: begin
                    if (on_a && d == 8'h20) begin nseq = 0; hit = 1; cmd = 4; end
                    else if (on_a && d == 8'h10) begin nseq = 0; hit = 1; cmd = 5; end
                    else brk = 1;
                end
            endcase
            if (brk) begin
                if (k1) begin nseq = 1; hit = 1; end else nseq = 0;
            end
        end
        eff   = (locked && cmd != 3) ? 0 : cmd;
        stray = w && !wopen && !hit;
        e_load = w && (wopen || (stray && !m_prot && !m_id && !locked));
        if (e_load) begin e_la = a; e_ld = d; end
        e_er  = (eff == 5);
        e_rdv = r && m_id;
        e_rdd = (ra == 0) ? 8'hBF : (ra == 1) ? DEV : 8'h00;
        if (stray && m_prot && !m_id && !locked) m_lock = LOCK;
        else if (eff == 3) m_lock = 0;
        else if (m_lock > 0) m_lock--;
        if (eff == 1 || (w && wopen)) m_win = WIN;
        else if (m_win > 0) m_win--;
        if (eff == 1) m_prot = 1;
        if (eff == 4) m_prot = 0;
        if (eff == 2) m_id = 1;
        if (eff == 3) m_id = 0;
        m_seq = nseq;
    endfunction

    task automatic model_cmp();
        logic [31:0] act, exp;
        act = {load_fire, erase_go, prot_on, id_mode, lock_busy, win_open, rd_valid,
               load_fire ? load_data : 8'h00, rd_valid ? rd_data : 8'h00};
        exp = {e_load, e_er, m_prot, m_id, (m_lock != 0), (m_win != 0), e_rdv,
               e_load ? e_ld : 8'h00, e_rdv ? e_rdd : 8'h00};
        checks++;
        if (act !== exp || (load_fire && load_addr !== e_la)) begin
            errors++;
            $display("FAIL model R2-model act=%h exp=%h addr act=%h exp=%h", act, exp, load_addr, e_la);
        end
    endtask

    task automatic drive(input bit w, input logic [16:0] a, input logic [7:0] d,
                         input bit r, input logic [16:0] ra);
        @(negedge clk);
        if (!rst) model_cmp();
        wr_en = w; wr_addr = a; wr_data = d; rd_en = r; rd_addr = ra;
        if (rst) model_reset();
        else     model_step(w, a, d, r, ra);
    endtask

    task automatic look();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        drive(1, a, d, 0, '0);
        look();
    endtask

    task automatic rdc(input logic [16:0] ra);
        drive(0, '0, 8'h00, 1, ra);
        look();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, '0, 8'h00, 0, '0);
        look();
    endtask

    task automatic seq3(input logic [7:0] op);
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h05555, op);
    endtask

    task automatic seq6(input logic [7:0] op);
        seq3(8'h80);
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h05555, op);
    endtask

    task automatic rnd_gap();
        int g = $urandom_range(0, 2);
        for (int i = 0; i < g; i++)
            drive(0, '0, 8'h00, $urandom_range(0, 1) == 1, 17'($urandom_range(0, 3)));
    endtask

    task automatic rnd_wr(input logic [14:0] a, input logic [7:0] d);
        logic [7:0] dd = d;
        if ($urandom_range(0, 99) < 8) dd = 8'($urandom);
        drive(1, {2'($urandom), a}, dd, 0, '0);
        rnd_gap();
    endtask

    task automatic rnd_script();
        int kind = $urandom_range(0, 7);
        logic [7:0] last;
        case (kind)
            0: last = 8'hA0;
            1: last = 8'h90;
            2: last = 8'hF0;
            default: last = 8'h80;
        endcase
        if (kind == 6) begin
            rnd_wr(15'($urandom), 8'($urandom));
        end else if (kind == 7) begin
            for (int i = 0; i < 3; i++) drive(0, '0, 8'h00, 1, 17'($urandom_range(0, 2)));
        end else begin
            rnd_wr(15'h5555, 8'hAA);
            rnd_wr(15'h2AAA, 8'h55);
            rnd_wr(15'h5555, last);
            if (kind == 4 || kind == 5) begin
                rnd_wr(15'h5555, 8'hAA);
                rnd_wr(15'h2AAA, 8'h55);
                rnd_wr(15'h5555, (kind == 4) ? 8'h20 : 8'h10);
            end
            if (kind == 0) begin
                int n = $urandom_range(1, 4);
                for (int i = 0; i < n; i++) rnd_wr(15'($urandom), 8'($urandom));
            end
        end
        if ($urandom_range(0, 15) == 0) idle(WIN + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) drive(0, '0, 8'h00, 0, '0);
        rst = 1'b0;
        look();

        // R1: reset state
        chk("R1 flags", {prot_on, id_mode, lock_busy, win_open}, 0);
        chk("R1 pulses", {load_fire, erase_go, rd_valid}, 0);

        // R2: unprotected direct load
        wr(17'h00123, 8'h5A);
        chk("R2 load_fire", load_fire, 1);
        chk("R2 load pair", {load_addr, load_data}, {17'h00123, 8'h5A});
        rdc(17'h0);
        chk("R8 no read outside id", rd_valid, 0);

        // R3: first unlock enables protection, upper address bits ignored
        wr(17'h15555, 8'hAA);
        chk("R3 key1 not loaded", load_fire, 0);
        wr(17'h02AAA, 8'h55);
        chk("R3 key2 not loaded", load_fire, 0);
        wr(17'h05555, 8'hA0);
        chk("R3 prot/win", {prot_on, win_open, load_fire}, 3'b110);

        // R4: window loads and restarts
        wr(17'h00200, 8'h33);
        chk("R4 window load", {load_fire, load_data}, {1'b1, 8'h33});
        idle(WIN - 1);
        chk("R4 still open", win_open, 1);
        wr(17'h00201, 8'h34);
        chk("R4 restart load", load_fire, 1);
        idle(WIN);
        chk("R4 window closed", win_open, 0);

        // R5: refused write and lockout
        wr(17'h00300, 8'h44);
        chk("R5 refused", {load_fire, lock_busy, prot_on}, 3'b011);
        wr(17'h00301, 8'h45);
        chk("R5 stray in lock", {load_fire, lock_busy}, 2'b01);
        idle(LOCK - 2);
        chk("R5 lock not extended, still on", lock_busy, 1);
        idle(1);
        chk("R5 lock ends", lock_busy, 0);

        // R12: commands masked during lockout, R9 exit releases it
        wr(17'h00310, 8'h46);
        chk("R12 lock start", lock_busy, 1);
        seq3(8'hA0);
        chk("R12 unlock masked", {win_open, load_fire, lock_busy}, 3'b001);
        seq6(8'h10);
        chk("R12 erase masked", erase_go, 0);
        seq3(8'hF0);
        chk("R9 exit ends lock", {lock_busy, id_mode}, 2'b00);

        // R7: erase pulse
        seq6(8'h10);
        chk("R7 erase pulse", {erase_go, prot_on}, 2'b11);
        idle(1);
        chk("R7 erase one cycle", erase_go, 0);

        // R8: identification mode reads
        seq3(8'h90);
        chk("R8 id_mode set", id_mode, 1);
        rdc(17'h0);
        chk("R8 mfr byte", {rd_valid, rd_data}, {1'b1, 8'hBF});
        rdc(17'h1);
        chk("R8 dev byte", {rd_valid, rd_data}, {1'b1, DEV});
        rdc(17'h5);
        chk("R8 other byte", {rd_valid, rd_data}, {1'b1, 8'h00});

        // R11: stray writes ignored in id mode
        wr(17'h00123, 8'h77);
        chk("R11 no load no lock", {load_fire, lock_busy}, 2'b00);

        // R9: exit
        seq3(8'hF0);
        chk("R9 id cleared", id_mode, 0);
        rdc(17'h0);
        chk("R9 no read after exit", rd_valid, 0);

        // R6: unprotect
        seq6(8'h20);
        chk("R6 prot cleared", prot_on, 0);
        wr(17'h00055, 8'h66);
        chk("R6 direct load again", {load_fire, lock_busy}, 2'b10);

        // R10: broken sequence, unprotected
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h00400, 8'h12);
        chk("R10 break loaded", {load_fire, load_addr, load_data, prot_on}, {1'b1, 17'h00400, 8'h12, 1'b0});
        wr(17'h05555, 8'hAA);
        wr(17'h05555, 8'hAA);
        chk("R10 restart consumed", load_fire, 0);
        wr(17'h02AAA, 8'h55);
        wr(17'h05555, 8'hA0);
        chk("R10 restarted unlock", {prot_on, win_open}, 2'b11);
        idle(WIN + 1);
        // R10: broken extended command under protection
        seq3(8'h80);
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h05555, 8'h21);
        chk("R10 partial unprotect no effect", {prot_on, lock_busy}, 2'b11);
        seq3(8'hF0);
        chk("R9 recovered", lock_busy, 0);

        // constrained random scripts against the model
        for (int i = 0; i < 2500; i++) rnd_script();
        idle(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule